// File: doc/BRIEF.md
# SPI Host Interrupt Status Unit

This unit holds the interrupt status and interrupt mask of a byte-oriented SPI host controller and drives its single level-sensitive interrupt line. FIFO fill counts, FIFO full flags and one-cycle event pulses (transmit underflow, receive overflow, mode fault) come in as plain inputs. The unit turns them into a seven-bit status word. Three bits of that word are sticky event flags. The other four are re-derived from FIFO state on every clock, by comparing the counts against two programmable thresholds.

Software reaches the unit over a small request bus with a fixed one-cycle response. Two write-only ports change the mask: one sets bits and the other clears them, so the mask itself never needs a read-modify-write. The status register is cleared by writing ones to it, and is also cleared when it is read. A linear-read mode input freezes all status updates while a memory-mapped flash fetch is in progress.

The request port is run by a two-state machine. `BUS_IDLE` means no response is pending. `BUS_RESP` means a response is on the outputs in this cycle. A request moves the machine from `BUS_IDLE` to `BUS_RESP` (transition *accept*). A further request keeps it in `BUS_RESP` (transition *chain*). No request sends it back to `BUS_IDLE` (transition *drain*).

Top module: `spi_irq_unit`

## Requirements
- R1: The status word has bit 6 = TX underflow, bit 5 = RX full, bit 4 = RX at threshold, bit 3 = TX full, bit 2 = TX below threshold, bit 1 = mode fault, bit 0 = RX overflow. A status read returns these seven bits with bits 31:7 zero.
- R2: Bits 6, 1 and 0 are sticky. An event pulse sets its bit, and the bit stays set until software clears it.
- R3: Bits 5, 4, 3 and 2 are refreshed every cycle from the inputs of the previous cycle. Bit 5 follows the RX full flag and bit 3 follows the TX full flag. Bit 4 is set when RX count ≥ RX threshold. Bit 2 is set when TX count < TX threshold.
- R4: Register addresses are 0 status, 1 mask-set, 2 mask-clear, 3 mask, 4 TX threshold, 5 RX threshold. A write to address 1 ORs data bits 6:0 into the mask. A write to address 2 clears the mask bits that are written as 1. A write to address 3 is ignored. Reads of addresses 1, 2, 6 and 7 return zero.
- R5: A write to the status address clears each sticky bit written as 1. A read of the status address returns the word and then clears all sticky bits. Live bits come back on the next refresh.
- R6: `irq` is high exactly when (mask AND status) is non-zero.
- R7: After reset, mask and status are 0 and both thresholds are 1. Writes to addresses 4 and 5 load the thresholds from the low data bits.
- R8: If an event pulse and a clear (write or read) hit the same sticky bit in the same cycle, the bit ends up set.
- R9: While `lin_mode` is high, events and FIFO state do not change the status word, and no underflow is recorded. Software clears still apply.
- R10: Every accepted request gets `rsp_valid` high in the next cycle, with the read data that was current when the request was accepted. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lin_mode | input | 1 | Linear-read mode; freezes status |
| tx_count | input | CW | TX FIFO fill level |
| rx_count | input | CW | RX FIFO fill level |
| tx_full | input | 1 | TX FIFO full |
| rx_full | input | 1 | RX FIFO full |
| ev_tx_underflow | input | 1 | TX underflow event pulse |
| ev_rx_overflow | input | 1 | RX overflow event pulse |
| ev_mode_fail | input | 1 | Mode fault event pulse |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | DW | Read data |
| irq | output | 1 | Level interrupt |

## Verification
Status and mask registers change on the clock edge that samples the stimulus. `irq` is combinational from those registers, so every status or mask effect is due one edge after its stimulus is applied. Read data appears with `rsp_valid` on that same edge and reflects the state just before the edge. The bench drives on the falling edge and compares on the next falling edge. Read expectations are queued by the driver and popped by a monitor as each response arrives, and `irq` is checked on the falling edge after the stimulus edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int NB = 7;

    localparam int B_TXUNF   = 6;
    localparam int B_RXFULL  = 5;
    localparam int B_RXAVAIL = 4;
    localparam int B_TXFULL  = 3;
    localparam int B_TXLOW   = 2;
    localparam int B_MFAIL   = 1;
    localparam int B_RXOVF   = 0;

    localparam logic [NB-1:0] STICKY = 7'b100_0011;

    localparam logic [2:0] A_STAT   = 3'd0;
    localparam logic [2:0] A_SETMSK = 3'd1;
    localparam logic [2:0] A_CLRMSK = 3'd2;
    localparam logic [2:0] A_MASK   = 3'd3;
    localparam logic [2:0] A_TXLVL  = 3'd4;
    localparam logic [2:0] A_RXLVL  = 3'd5;

    typedef enum logic {BUS_IDLE, BUS_RESP} bus_state_e;
endpackage

// File: rtl/spi_irq_regif.sv
module spi_irq_regif
    import spi_irq_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [2:0]    req_addr,
    input  logic [NB-1:0] wd_bits,
    input  logic [NB-1:0] status_q,
    input  logic [NB-1:0] mask_q,
    input  logic [CW-1:0] tx_thr,
    input  logic [CW-1:0] rx_thr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [NB-1:0] stat_clr,
    output logic [NB-1:0] mask_set,
    output logic [NB-1:0] mask_clr,
    output logic          txthr_we,
    output logic          rxthr_we
);
    bus_state_e state_q, state_d;
    logic [DW-1:0] rd_mux;
    logic          is_wr, is_rd;

    assign is_wr = req_valid &&  req_write;
    assign is_rd = req_valid && !req_write;

    // write-side decode
    always_comb begin
        stat_clr = '0;
        mask_set = '0;
        mask_clr = '0;
        txthr_we = 1'b0;
        rxthr_we = 1'b0;
        if (is_wr) begin
            case (req_addr)
                A_STAT:   stat_clr = wd_bits;
                A_SETMSK: mask_set = wd_bits;
                A_CLRMSK: mask_clr = wd_bits;
                A_TXLVL:  txthr_we = 1'b1;
                A_RXLVL:  rxthr_we = 1'b1;
                default:  ;
            endcase
        end else if (is_rd && req_addr == A_STAT) begin
            stat_clr = '1;
        end
    end

    // read mux
    always_comb begin
        rd_mux = '0;
        if (is_rd) begin
            case (req_addr)
                A_STAT:  rd_mux = {{(DW-NB){1'b0}}, status_q};
                A_MASK:  rd_mux = {{(DW-NB){1'b0}}, mask_q};
                A_TXLVL: rd_mux = {{(DW-CW){1'b0}}, tx_thr};
                A_RXLVL: rd_mux = {{(DW-CW){1'b0}}, rx_thr};
                default: rd_mux = '0;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_valid) state_d = BUS_RESP;   // accept
            BUS_RESP: state_d = req_valid ? BUS_RESP        // chain
                                          : BUS_IDLE;       // drain
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)         rsp_rdata <= '0;
        else if (req_valid) rsp_rdata <= rd_mux;
    end

    assign rsp_valid = (state_q == BUS_RESP);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lin_mode,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic          tx_full,
    input  logic          rx_full,
    input  logic          ev_tx_underflow,
    input  logic          ev_rx_overflow,
    input  logic          ev_mode_fail,
    input  logic [CW-1:0] tx_thr,
    input  logic [CW-1:0] rx_thr,
    input  logic [NB-1:0] stat_clr,
    output logic [NB-1:0] status_q
);
    logic [NB-1:0] live, evv;

    always_comb begin
        live = '0;
        live[B_RXFULL]  = rx_full;
        live[B_RXAVAIL] = (rx_count >= rx_thr);
        live[B_TXFULL]  = tx_full;
        live[B_TXLOW]   = (tx_count < tx_thr);
        evv = '0;
        evv[B_TXUNF]    = ev_tx_underflow;
        evv[B_MFAIL]    = ev_mode_fail;
        evv[B_RXOVF]    = ev_rx_overflow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        status_q <= '0;
        else if (lin_mode) status_q <= status_q & ~stat_clr;
        else               status_q <= (status_q & STICKY & ~stat_clr) | evv | live;
    end
endmodule

// File: rtl/spi_irq_cfg.sv
module spi_irq_cfg
    import spi_irq_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] mask_set,
    input  logic [NB-1:0] mask_clr,
    input  logic          txthr_we,
    input  logic          rxthr_we,
    input  logic [CW-1:0] thr_wd,
    output logic [NB-1:0] mask_q,
    output logic [CW-1:0] tx_thr,
    output logic [CW-1:0] rx_thr
);
    localparam logic [CW-1:0] THR_RST = CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            tx_thr <= THR_RST;
            rx_thr <= THR_RST;
        end else begin
            mask_q <= (mask_q | mask_set) & ~mask_clr;
            if (txthr_we) tx_thr <= thr_wd;
            if (rxthr_we) rx_thr <= thr_wd;
        end
    end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int DW         = 32,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lin_mode,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic          tx_full,
    input  logic          rx_full,
    input  logic          ev_tx_underflow,
    input  logic          ev_rx_overflow,
    input  logic          ev_mode_fail,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [2:0]    req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          irq
);
    logic [NB-1:0] status_q, mask_q, stat_clr, mask_set, mask_clr;
    logic [CW-1:0] tx_thr, rx_thr;
    logic          txthr_we, rxthr_we;
    logic          unused_wdata;

    assign unused_wdata = ^req_wdata[DW-1:NB];

    spi_irq_regif #(.DW(DW), .CW(CW)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .wd_bits(req_wdata[NB-1:0]),
        .status_q(status_q), .mask_q(mask_q), .tx_thr(tx_thr), .rx_thr(rx_thr),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .stat_clr(stat_clr), .mask_set(mask_set), .mask_clr(mask_clr),
        .txthr_we(txthr_we), .rxthr_we(rxthr_we)
    );

    spi_irq_status #(.CW(CW)) u_status (
        .clk(clk), .rst_n(rst_n), .lin_mode(lin_mode),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_full(tx_full), .rx_full(rx_full),
        .ev_tx_underflow(ev_tx_underflow), .ev_rx_overflow(ev_rx_overflow),
        .ev_mode_fail(ev_mode_fail),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .stat_clr(stat_clr), .status_q(status_q)
    );

    spi_irq_cfg #(.CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .mask_set(mask_set), .mask_clr(mask_clr),
        .txthr_we(txthr_we), .rxthr_we(rxthr_we),
        .thr_wd(req_wdata[CW-1:0]),
        .mask_q(mask_q), .tx_thr(tx_thr), .rx_thr(rx_thr)
    );

    assign irq = |(mask_q & status_q);
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
    import spi_irq_pkg::*;
#(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lin_mode,
    input logic          rx_full,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] rx_thr,
    input logic          ev_tx_underflow,
    input logic          ev_rx_overflow,
    input logic          ev_mode_fail,
    input logic          req_valid,
    input logic          req_write,
    input logic [2:0]    req_addr,
    input logic [NB-1:0] wd_bits,
    input logic [NB-1:0] status_q,
    input logic [NB-1:0] mask_q,
    input logic          rsp_valid
);
    // R2
    sticky_mfail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lin_mode && ev_mode_fail) |=> status_q[B_MFAIL]);
    // R3
    live_rxfull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lin_mode |=> (status_q[B_RXFULL] == $past(rx_full)));
    // R3
    live_rxavail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lin_mode |=> (status_q[B_RXAVAIL] == ($past(rx_count) >= $past(rx_thr))));
    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == A_SETMSK)
        |=> ((mask_q & $past(wd_bits)) == $past(wd_bits)));
    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == A_CLRMSK)
        |=> ((mask_q & $past(wd_bits)) == '0));
    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == A_STAT
         && !ev_tx_underflow && !ev_rx_overflow && !ev_mode_fail)
        |=> ((status_q & STICKY) == '0));
    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_mode && !req_valid) |=> $stable(status_q));
    // R9
    no_unf_lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_mode && !status_q[B_TXUNF]) |=> !status_q[B_TXUNF]);
    // R10
    rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
endmodule

bind spi_irq_unit spi_irq_chk #(.CW(CW)) i_chk (
    .clk(clk), .rst_n(rst_n), .lin_mode(lin_mode),
    .rx_full(rx_full), .rx_count(rx_count), .rx_thr(rx_thr),
    .ev_tx_underflow(ev_tx_underflow), .ev_rx_overflow(ev_rx_overflow),
    .ev_mode_fail(ev_mode_fail),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .wd_bits(req_wdata[6:0]), .status_q(status_q), .mask_q(mask_q),
    .rsp_valid(rsp_valid)
);

// File: tb/test_spi_irq_unit.sv
`timescale 1ns/1ps
module test_spi_irq_unit;
    localparam int CW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lin_mode = 1'b0;
    logic [CW-1:0] tx_count = '0, rx_count = '0;
    logic          tx_full = 1'b0, rx_full = 1'b0;
    logic          ev_tx_underflow = 1'b0, ev_rx_overflow = 1'b0, ev_mode_fail = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]    req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic          chk;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    spi_irq_unit #(.FIFO_DEPTH(32), .DW(DW)) i_spi_irq_unit (
        .clk(clk), .rst_n(rst_n), .lin_mode(lin_mode),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_full(tx_full), .rx_full(rx_full),
        .ev_tx_underflow(ev_tx_underflow), .ev_rx_overflow(ev_rx_overflow),
        .ev_mode_fail(ev_mode_fail),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pop one expectation per response (R10)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check("R10 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.chk) check(e.tag, rsp_rdata, e.data);
            end
        end
    end

    task automatic access(input logic wr, input logic [2:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        exp_t e;
        e.chk = 1'b1; e.data = '0; e.tag = "R10 write data";
        sb.push_back(e);
        access(1'b1, a, d);
    endtask

    task automatic rd(input logic [2:0] a, input logic [DW-1:0] exp, input string tag);
        exp_t e;
        e.chk = 1'b1; e.data = exp; e.tag = tag;
        sb.push_back(e);
        access(1'b0, a, '0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_unf();
        ev_tx_underflow = 1'b1; @(negedge clk); ev_tx_underflow = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R7 reset state
        check("R7 irq after reset", irq, 0);
        rd(3'd3, 32'h0, "R7 mask reset");
        rd(3'd4, 32'h1, "R7 tx threshold reset");
        rd(3'd5, 32'h1, "R7 rx threshold reset");
        rd(3'd0, 32'h04, "R3 R1 tx below threshold after reset");
        rd(3'd1, 32'h0, "R4 mask-set reads zero");
        rd(3'd7, 32'h0, "R4 unused address reads zero");

        // R3 live bits
        rx_count = 3; tx_count = 5; tx_full = 1; rx_full = 1;
        idle(2);
        rd(3'd0, 32'h38, "R3 live bits");
        rd(3'd0, 32'h38, "R5 live bits survive read");
        tx_full = 0; rx_full = 0; rx_count = 0; tx_count = 0;
        idle(2);

        // R2 sticky, R5 read clears
        ev_mode_fail = 1; idle(1); ev_mode_fail = 0;
        rd(3'd0, 32'h06, "R2 mode fault sticky");
        rd(3'd0, 32'h04, "R5 read clears sticky");
        pulse_unf();
        idle(5);
        rd(3'd0, 32'h44, "R2 underflow persists");

        // R5 write-1-to-clear
        ev_rx_overflow = 1; ev_mode_fail = 1; idle(1);
        ev_rx_overflow = 0; ev_mode_fail = 0;
        wr(3'd0, 32'h01);
        rd(3'd0, 32'h06, "R5 w1c clears only written bit");

        // R4 mask
        wr(3'd1, 32'h41);
        rd(3'd3, 32'h41, "R4 mask set");
        wr(3'd2, 32'h01);
        rd(3'd3, 32'h40, "R4 mask clear");
        wr(3'd3, 32'h7F);
        rd(3'd3, 32'h40, "R4 mask write ignored");
        rd(3'd2, 32'h0, "R4 mask-clear reads zero");

        // R6 irq
        check("R6 irq low, masked bit clear", irq, 0);
        pulse_unf();
        check("R6 irq on masked sticky", irq, 1);
        wr(3'd0, 32'h40);
        check("R6 irq drops after clear", irq, 0);
        wr(3'd1, 32'h04);
        check("R6 irq on masked live bit", irq, 1);
        wr(3'd2, 32'h04);
        check("R6 irq drops after unmask", irq, 0);

        // R7 thresholds
        wr(3'd4, 32'h8);
        wr(3'd5, 32'h4);
        tx_count = 5; rx_count = 3;
        idle(2);
        rd(3'd0, 32'h04, "R7 thresholds 8/4 counts 5/3");
        rx_count = 4;
        idle(2);
        rd(3'd0, 32'h14, "R7 rx count equals threshold");
        tx_count = 8;
        idle(2);
        rd(3'd0, 32'h10, "R7 tx count equals threshold");
        rd(3'd4, 32'h8, "R7 tx threshold readback");

        // R8 event wins over clear
        ev_mode_fail = 1;
        wr(3'd0, 32'h02);
        ev_mode_fail = 0;
        rd(3'd0, 32'h12, "R8 event beats w1c");
        ev_rx_overflow = 1;
        rd(3'd0, 32'h10, "R8 read sees pre-edge word");
        ev_rx_overflow = 0;
        rd(3'd0, 32'h11, "R8 event beats read clear");

        // R9 linear-read freeze
        lin_mode = 1;
        idle(1);
        pulse_unf();
        ev_mode_fail = 1; idle(1); ev_mode_fail = 0;
        rx_count = 0; tx_count = 0; rx_full = 1;
        idle(3);
        rd(3'd0, 32'h10, "R9 status frozen");
        rd(3'd0, 32'h00, "R9 clear applies while frozen");
        lin_mode = 0;
        rx_full = 0;
        idle(2);
        rd(3'd0, 32'h04, "R9 no underflow recorded");

        idle(3);
        check("R10 all responses seen", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule